// File: doc/BRIEF.md
# Four-Bank Row and Burst Tracker

This block follows the command stream of a four-bank dynamic memory and keeps track of what each bank is doing. A command, a bank address and an address word are sampled on every rising clock edge. Opening a row in a bank makes that bank "open" and stores the row number. Later column accesses to an open bank start a data burst. The block reports which bank and starting column the burst uses and how long it lasts.

Opening a bank that is already open, or accessing a bank that is closed, is flagged on a one-cycle error output, and no state changes. Column accesses can ask for the bank to close on its own when the burst finishes. Explicit close commands shut one bank or all banks. A controller, or a checker placed next to a controller, uses the outputs to see the state of every bank and of the single burst in flight.

Top module: `bank_tracker`

## Requirements
- R1: While reset is held, and until the first command after reset, all four banks report closed, the burst-busy output is low and the error output is low.
- R2: Command code 1 (OPEN) to a closed bank opens it. From the next cycle, the bank reads open and its row output holds addr_i[13:0].
- R3: The banks are independent. Opening or closing one bank leaves the open flag and row of every other bank unchanged.
- R4: An illegal command raises err_o for exactly the next cycle and changes no bank or burst state. The illegal cases are: OPEN to an open bank, and a READ (code 2) or WRITE (code 3) to a closed bank.
- R5: A READ or WRITE to an open bank raises burst_busy_o for BL/2 cycles, starting in the cycle after the command. For that whole time burst_bank_o shows the bank and burst_col_o shows addr_i[9:0].
- R6: Command code 5 (SETLEN) sets the burst length BL from addr_i[2:0]: 1 selects 2, 2 selects 4 and 3 selects 8. Any other code leaves BL unchanged. After reset BL is 4.
- R7: A READ or WRITE with addr_i[10] set closes its bank at the same edge where the burst ends. burst_busy_o and that bank's open flag fall in the same cycle.
- R8: Command code 4 (CLOSE) with addr_i[10] clear closes bank ba_i. With addr_i[10] set it closes all banks. Closing a closed bank is not an error.
- R9: A READ or WRITE issued while a burst without self-close is running restarts the burst with the new bank, column and length. A READ or WRITE issued while a self-closing burst is running is illegal, as in R4.
- R10: Command codes 0, 6 and 7 are no-operations. They change no state and raise no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; commands sampled on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_i | input | 3 | Command code: 0 none, 1 open, 2 read, 3 write, 4 close, 5 set length |
| ba_i | input | 2 | Bank address |
| addr_i | input | 14 | Row for open; column in [9:0] and self-close flag in [10] for read/write; all-banks flag in [10] for close; length code in [2:0] for set length |
| bank_open_o | output | 4 | One bit per bank, set while the bank holds an open row |
| open_row_o | output | 56 | Row of bank i in bits [14*i+13:14*i] |
| burst_busy_o | output | 1 | High while a burst is in progress |
| burst_bank_o | output | 2 | Bank of the current or last burst |
| burst_col_o | output | 10 | Start column of the current or last burst |
| err_o | output | 1 | One-cycle pulse after an illegal command |

## Verification
All results are registered once. A command sampled at edge N shows up in the open flags, row outputs, burst outputs and error flag just after edge N. A burst of length BL keeps burst_busy_o high through edge N+BL/2, and a self-closing bank drops its open flag at that same edge. The bench drives each command at the falling edge. A reference model then pushes the expected post-edge outputs into a queue, and a monitor pops and compares them 2 ns after the next rising edge. Every check is therefore made in the one cycle its result is due.

// File: rtl/bank_trk_pkg.sv
package bank_trk_pkg;
  localparam logic [2:0] CMD_NOP  = 3'd0;
  localparam logic [2:0] CMD_OPEN = 3'd1;
  localparam logic [2:0] CMD_RD   = 3'd2;
  localparam logic [2:0] CMD_WR   = 3'd3;
  localparam logic [2:0] CMD_CLS  = 3'd4;
  localparam logic [2:0] CMD_LEN  = 3'd5;
endpackage

// File: rtl/bank_trk_decode.sv
module bank_trk_decode
  import bank_trk_pkg::*;
#(
  parameter int NB     = 4,
  parameter int BA_W   = 2,
  parameter int ADDR_W = 14,
  parameter int AP_BIT = 10,
  parameter int HALF_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_n,
  input  logic [2:0]        cmd_i,
  input  logic [BA_W-1:0]   ba_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NB-1:0]     bank_open,
  input  logic              ap_busy,
  output logic              open_ok,
  output logic              acc_ok,
  output logic              cls_one,
  output logic              cls_all,
  output logic              ap_req,
  output logic [HALF_W-1:0] half_len,
  output logic              err_o
);
  logic              tgt_open, is_open, is_acc, is_cls, is_len, illegal;
  logic [HALF_W-1:0] half_d;

  always_comb begin
    tgt_open = bank_open[ba_i];
    is_open  = (cmd_i == CMD_OPEN);
    is_acc   = (cmd_i == CMD_RD) || (cmd_i == CMD_WR);
    is_cls   = (cmd_i == CMD_CLS);
    is_len   = (cmd_i == CMD_LEN);
    illegal  = (is_open && tgt_open) || (is_acc && (!tgt_open || ap_busy));
    open_ok  = is_open && !tgt_open;
    acc_ok   = is_acc && tgt_open && !ap_busy;
    cls_all  = is_cls && addr_i[AP_BIT];
    cls_one  = is_cls && !addr_i[AP_BIT];
    ap_req   = addr_i[AP_BIT];
    half_d   = half_len;
    if (is_len) begin
      case (addr_i[2:0])
        3'd1:    half_d = HALF_W'(1);
        3'd2:    half_d = HALF_W'(2);
        3'd3:    half_d = HALF_W'(4);
        default: half_d = half_len;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      half_len <= HALF_W'(2);
      err_o    <= 1'b0;
    end else begin
      if (is_len) half_len <= half_d;
      err_o <= illegal;
    end
  end

  a_r4_err_follows_illegal: assert property (@(posedge clk_i) disable iff (!rst_n)
    illegal |=> err_o);
  a_r6_len_onehot: assert property (@(posedge clk_i) disable iff (!rst_n)
    $countones(half_len) == 1);
endmodule

// File: rtl/bank_trk_slot.sv
module bank_trk_slot #(
  parameter int ROW_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_n,
  input  logic             open_set,
  input  logic             close,
  input  logic [ROW_W-1:0] row_d,
  output logic             open_q,
  output logic [ROW_W-1:0] row_q
);
  logic open_d;

  always_comb begin
    open_d = open_q;
    if (open_set)   open_d = 1'b1;
    else if (close) open_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      row_q  <= '0;
    end else begin
      open_q <= open_d;
      if (open_set) row_q <= row_d;
    end
  end

  a_r2_open_loads_row: assert property (@(posedge clk_i) disable iff (!rst_n)
    open_set |=> (open_q && row_q == $past(row_d)));
  a_r8_close_idles: assert property (@(posedge clk_i) disable iff (!rst_n)
    (close && !open_set) |=> !open_q);
endmodule

// File: rtl/bank_trk_burst.sv
module bank_trk_burst #(
  parameter int HALF_W = 3,
  parameter int BA_W   = 2,
  parameter int COL_W  = 10,
  parameter int MAX_HALF = 4
) (
  input  logic              clk_i,
  input  logic              rst_n,
  input  logic              start,
  input  logic              ap_in,
  input  logic [HALF_W-1:0] half_len,
  input  logic [BA_W-1:0]   bank_in,
  input  logic [COL_W-1:0]  col_in,
  output logic              busy,
  output logic              ap_busy,
  output logic              ap_done,
  output logic [BA_W-1:0]   bank_q,
  output logic [COL_W-1:0]  col_q
);
  logic [HALF_W-1:0] cnt_q, cnt_d;
  logic              ap_q, ap_d;

  always_comb begin
    busy    = (cnt_q != '0);
    ap_busy = ap_q;
    ap_done = ap_q && (cnt_q == HALF_W'(1));
    cnt_d   = cnt_q;
    ap_d    = ap_q;
    if (start) begin
      cnt_d = half_len;
      ap_d  = ap_in;
    end else if (busy) begin
      cnt_d = cnt_q - HALF_W'(1);
      if (cnt_q == HALF_W'(1)) ap_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      ap_q   <= 1'b0;
      bank_q <= '0;
      col_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      ap_q  <= ap_d;
      if (start) begin
        bank_q <= bank_in;
        col_q  <= col_in;
      end
    end
  end

  a_r5_count_bound: assert property (@(posedge clk_i) disable iff (!rst_n)
    cnt_q <= HALF_W'(MAX_HALF));
  a_r7_ap_ends_burst: assert property (@(posedge clk_i) disable iff (!rst_n)
    ap_done |=> !busy);
endmodule

// File: rtl/bank_tracker.sv
module bank_tracker #(
  parameter int NB       = 4,
  parameter int ROW_W    = 14,
  parameter int COL_W    = 10,
  parameter int ADDR_W   = 14,
  parameter int AP_BIT   = 10,
  parameter int MAX_BURST = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [2:0]          cmd_i,
  input  logic [$clog2(NB)-1:0] ba_i,
  input  logic [ADDR_W-1:0]   addr_i,
  output logic [NB-1:0]       bank_open_o,
  output logic [NB*ROW_W-1:0] open_row_o,
  output logic                burst_busy_o,
  output logic [$clog2(NB)-1:0] burst_bank_o,
  output logic [COL_W-1:0]    burst_col_o,
  output logic                err_o
);
  localparam int BA_W     = $clog2(NB);
  localparam int MAX_HALF = MAX_BURST / 2;
  localparam int HALF_W   = $clog2(MAX_HALF + 1);

  logic [1:0]        rst_sync_q;
  logic              rst_n;
  logic              open_ok, acc_ok, cls_one, cls_all, ap_req;
  logic              ap_busy, ap_done;
  logic [HALF_W-1:0] half_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  bank_trk_decode #(
    .NB(NB), .BA_W(BA_W), .ADDR_W(ADDR_W), .AP_BIT(AP_BIT), .HALF_W(HALF_W)
  ) u_decode (
    .clk_i(clk_i), .rst_n(rst_n), .cmd_i(cmd_i), .ba_i(ba_i), .addr_i(addr_i),
    .bank_open(bank_open_o), .ap_busy(ap_busy), .open_ok(open_ok),
    .acc_ok(acc_ok), .cls_one(cls_one), .cls_all(cls_all), .ap_req(ap_req),
    .half_len(half_len), .err_o(err_o)
  );

  bank_trk_burst #(
    .HALF_W(HALF_W), .BA_W(BA_W), .COL_W(COL_W), .MAX_HALF(MAX_HALF)
  ) u_burst (
    .clk_i(clk_i), .rst_n(rst_n), .start(acc_ok), .ap_in(ap_req),
    .half_len(half_len), .bank_in(ba_i), .col_in(addr_i[COL_W-1:0]),
    .busy(burst_busy_o), .ap_busy(ap_busy), .ap_done(ap_done),
    .bank_q(burst_bank_o), .col_q(burst_col_o)
  );

  for (genvar gi = 0; gi < NB; gi++) begin : g_bank
    logic sel, set_b, close_b;
    always_comb begin
      sel     = (ba_i == BA_W'(gi));
      set_b   = open_ok && sel;
      close_b = cls_all || (cls_one && sel) ||
                (ap_done && burst_bank_o == BA_W'(gi));
    end
    bank_trk_slot #(.ROW_W(ROW_W)) u_slot (
      .clk_i(clk_i), .rst_n(rst_n), .open_set(set_b), .close(close_b),
      .row_d(addr_i[ROW_W-1:0]), .open_q(bank_open_o[gi]),
      .row_q(open_row_o[gi*ROW_W +: ROW_W])
    );
  end

  a_r7_self_close: assert property (@(posedge clk_i) disable iff (!rst_n)
    ap_done |=> !bank_open_o[$past(burst_bank_o)]);
  a_r8_close_all: assert property (@(posedge clk_i) disable iff (!rst_n)
    (cmd_i == bank_trk_pkg::CMD_CLS && addr_i[AP_BIT]) |=> bank_open_o == '0);
endmodule

// File: tb/bank_tracker_tb.sv
module bank_tracker_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [2:0]  cmd_i;
  logic [1:0]  ba_i;
  logic [13:0] addr_i;
  logic [3:0]  bank_open_o;
  logic [55:0] open_row_o;
  logic        burst_busy_o;
  logic [1:0]  burst_bank_o;
  logic [9:0]  burst_col_o;
  logic        err_o;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [3:0]  open;
    logic [55:0] rows;
    logic        busy;
    logic        err;
    logic [1:0]  bank;
    logic [9:0]  col;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  logic [3:0]  m_open;
  logic [13:0] m_row [4];
  int          m_cnt, m_half;
  logic        m_ap;
  logic [1:0]  m_bank;
  logic [9:0]  m_col;
  logic        m_err;

  always #5 clk_i = ~clk_i;

  bank_tracker u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmd_i(cmd_i), .ba_i(ba_i), .addr_i(addr_i),
    .bank_open_o(bank_open_o), .open_row_o(open_row_o),
    .burst_busy_o(burst_busy_o), .burst_bank_o(burst_bank_o),
    .burst_col_o(burst_col_o), .err_o(err_o)
  );

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // reference model, derived from the requirement list
  task automatic model(input logic [2:0] c, input logic [1:0] b, input logic [13:0] a);
    logic start = 1'b0;
    logic ap_end = m_ap && (m_cnt == 1);
    logic [1:0] end_bank = m_bank;
    m_err = 1'b0;
    case (c)
      3'd1: if (m_open[b]) m_err = 1'b1;
            else begin m_open[b] = 1'b1; m_row[b] = a; end
      3'd2, 3'd3:
            if (!m_open[b] || m_ap) m_err = 1'b1;
            else begin
              start = 1'b1; m_cnt = m_half; m_ap = a[10]; m_bank = b; m_col = a[9:0];
            end
      3'd4: if (a[10]) m_open = '0; else m_open[b] = 1'b0;
      3'd5: case (a[2:0])
              3'd1: m_half = 1;
              3'd2: m_half = 2;
              3'd3: m_half = 4;
              default: ;
            endcase
      default: ;
    endcase
    if (!start && m_cnt != 0) begin
      if (ap_end) begin m_open[end_bank] = 1'b0; m_ap = 1'b0; end
      m_cnt--;
    end
  endtask

  task automatic step(input logic [2:0] c, input logic [1:0] b,
                      input logic [13:0] a, input string tag);
    exp_t e;
    @(negedge clk_i);
    cmd_i = c; ba_i = b; addr_i = a;
    model(c, b, a);
    e.open = m_open;
    for (int i = 0; i < 4; i++) e.rows[i*14 +: 14] = m_row[i];
    e.busy = (m_cnt != 0); e.err = m_err;
    e.bank = m_bank; e.col = m_col; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(3'd0, 2'd0, 14'd0, tag);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk_i);
      #2;
      if (sb_q.size() > 0) begin
        e = sb_q.pop_front();
        chk(e.tag, "open", 64'(bank_open_o), 64'(e.open));
        chk(e.tag, "busy", 64'(burst_busy_o), 64'(e.busy));
        chk(e.tag, "err", 64'(err_o), 64'(e.err));
        for (int i = 0; i < 4; i++)
          if (e.open[i]) chk(e.tag, "row", 64'(open_row_o[i*14 +: 14]), 64'(e.rows[i*14 +: 14]));
        if (e.busy) begin
          chk(e.tag, "bank", 64'(burst_bank_o), 64'(e.bank));
          chk(e.tag, "col", 64'(burst_col_o), 64'(e.col));
        end
      end
    end
  end

  initial begin : watchdog
    #1ms;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    m_open = '0; m_cnt = 0; m_half = 2; m_ap = 1'b0; m_bank = '0; m_col = '0; m_err = 1'b0;
    for (int i = 0; i < 4; i++) m_row[i] = '0;
    cmd_i = 3'd0; ba_i = '0; addr_i = '0;
    rst_ni = 1'b0;
    repeat (3) @(posedge clk_i);
    #2;
    chk("R1", "open", 64'(bank_open_o), 64'd0);
    chk("R1", "busy", 64'(burst_busy_o), 64'd0);
    chk("R1", "err", 64'(err_o), 64'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(posedge clk_i);
    #2;
    chk("R1", "open after release", 64'(bank_open_o), 64'd0);
    chk("R1", "busy after release", 64'(burst_busy_o), 64'd0);

    step(3'd1, 2'd0, 14'h0123, "R2");
    step(3'd1, 2'd2, 14'h3FFF, "R3");
    step(3'd2, 2'd1, 14'h0004, "R4");          // read to closed bank
    step(3'd1, 2'd0, 14'h0555, "R4");          // open an open bank
    step(3'd3, 2'd0, 14'h0015, "R5");          // BL 4 from reset (R6)
    idle(3, "R5");
    step(3'd5, 2'd0, 14'h0003, "R6");          // BL 8
    step(3'd2, 2'd2, 14'h0007, "R6");
    idle(5, "R6");
    step(3'd5, 2'd0, 14'h0007, "R6");          // ignored code
    step(3'd2, 2'd0, 14'h03FF, "R6");
    idle(5, "R6");
    step(3'd5, 2'd0, 14'h0001, "R6");          // BL 2
    step(3'd2, 2'd0, 14'h0403, "R7");          // self-close, 1 cycle
    idle(1, "R7");
    step(3'd2, 2'd0, 14'h0003, "R7");          // bank now closed -> error
    step(3'd5, 2'd0, 14'h0003, "R9");          // BL 8
    step(3'd1, 2'd0, 14'h0005, "R9");
    step(3'd3, 2'd2, 14'h0409, "R9");          // self-closing burst on bank 2
    step(3'd2, 2'd0, 14'h0001, "R9");          // illegal during it
    idle(4, "R7");
    step(3'd1, 2'd2, 14'h0ABC, "R9");
    step(3'd2, 2'd0, 14'h0011, "R9");
    step(3'd3, 2'd2, 14'h0022, "R9");          // restart
    idle(5, "R9");
    step(3'd4, 2'd0, 14'h0000, "R8");
    step(3'd4, 2'd0, 14'h0000, "R8");          // close closed bank: no error
    step(3'd1, 2'd1, 14'h0111, "R3");
    step(3'd1, 2'd3, 14'h0333, "R3");
    step(3'd6, 2'd1, 14'h0400, "R10");
    step(3'd7, 2'd3, 14'h0000, "R10");
    step(3'd4, 2'd1, 14'h0400, "R8");          // close all
    idle(2, "R10");
    wait (sb_q.size() == 0);
    @(negedge clk_i);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule